// File: doc/BRIEF.md
# Display Interrupt Controller

This block gathers four event sources from a display pipeline into one 32-bit control word and drives a single interrupt line. The four sources are a display-hold-valid pulse, a frame-start pulse, a bus-error pulse, and a line-flag event. The line-flag event is raised inside the block when a current-scan-line input reaches a line number that software has programmed.

Each source owns a sticky status bit. An event sets that bit and it stays set until software clears it. Clearing uses a write-one-to-clear field held in the same word, so no read-modify-write of the status is needed. Per-source enable bits decide which set status bits reach the interrupt output.

A write replaces the enable field and the line-number field together in one cycle. Clear bits act only on the cycle of the write. The word is read back combinationally.

Top module: `disp_irq_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), rd_data reads 0 and irq is low: all status bits, enable bits and the line-number field are zero.
- R2: A one-cycle pulse on a source input sets that source's status bit, readable from the next cycle on. The bit positions are 0 for display-hold-valid, 1 for frame-start, 2 for line-flag and 3 for bus-error. The bit then stays set with no further events.
- R3: A write stores wr_data[7:4] as the per-source enable bits, in the same source order as the status bits, and rd_data[7:4] returns them.
- R4: A write with wr_data[8+i] = 1 clears status bit i from the next cycle on. Status bits whose clear bit is 0 keep their value.
- R5: If a source event and that source's clear arrive in the same cycle, the event wins and the status bit stays set.
- R6: rd_data[11:8] (the clear field) always reads 0.
- R7: A write stores wr_data[24:12] as the 13-bit line number, and rd_data[24:12] returns it. rd_data[31:25] always reads 0.
- R8: Line-flag status (bit 2) sets in the cycle after cur_line first equals the programmed line number. It does not set again while cur_line stays equal. It sets again once cur_line has differed and then matches once more. This holds up to the maximum value 8191.
- R9: irq is high exactly when some source has both its status bit and its enable bit set. A status bit records its event even when the source is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data: enables [7:4], clears [11:8], line number [24:12] |
| rd_data | output | 32 | Read data: status [3:0], enables [7:4], zero [11:8], line number [24:12] |
| evt_hold | input | 1 | Display-hold-valid event pulse |
| evt_frame | input | 1 | Frame-start event pulse |
| evt_bus_err | input | 1 | Bus-error event pulse |
| cur_line | input | 13 | Current scan line from the timing generator |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the event inputs, wr_en, wr_data and cur_line are known values whenever reset is released. They also assume that reset is held low from time zero until after the first clock edge. The line-flag check further assumes that a rise of status bit 2 can only follow a match of cur_line with the stored line number at the previous edge. That is true only because no other source touches bit 2. The bench meets these assumptions by driving every input to a defined level before the first edge. It changes inputs only on falling edges. It also parks cur_line on a value away from the programmed line, so that a match happens only when a scenario asks for one.

// File: rtl/disp_irq_pkg.sv
// Package: shared widths and field positions of the display interrupt word.
// Assumes four sources in the fixed order hold-valid, frame-start,
// line-flag, bus-error.
package disp_irq_pkg;
    localparam int NUM_SRC    = 4;
    localparam int LINE_W     = 13;
    localparam int WORD_W     = 32;
    localparam int STAT_LSB   = 0;
    localparam int EN_LSB     = STAT_LSB + NUM_SRC;
    localparam int CLR_LSB    = EN_LSB + NUM_SRC;
    localparam int LINE_LSB   = CLR_LSB + NUM_SRC;
    localparam int LINE_MSB   = LINE_LSB + LINE_W - 1;

    localparam int SRC_HOLD   = 0;
    localparam int SRC_FRAME  = 1;
    localparam int SRC_LINE   = 2;
    localparam int SRC_BUSERR = 3;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [LINE_W-1:0]  line_t;
endpackage

// File: rtl/disp_irq_cfg.sv
// Module: holds the writable configuration (enable bits and line number).
// Assumes a write replaces both fields at once.
module disp_irq_cfg
    import disp_irq_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int LW    = LINE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [N_SRC-1:0] wr_en_bits,
    input  logic [LW-1:0]    wr_line,
    output logic [N_SRC-1:0] en_q,
    output logic [LW-1:0]    line_q
);
    // Configuration register: cleared by reset, loaded by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            line_q <= '0;
        end else if (wr_en) begin
            en_q   <= wr_en_bits;
            line_q <= wr_line;
        end
    end
endmodule

// File: rtl/disp_line_det.sv
// Module: turns a level match of the scan line against the programmed line
// into a single-cycle event on the first cycle of each match.
// Assumes cur_line is synchronous to clk.
module disp_line_det
    import disp_irq_pkg::*;
#(
    parameter int LW = LINE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] cur_line,
    input  logic [LW-1:0] cmp_line,
    output logic          hit
);
    logic match;
    logic match_q;

    // Compare the current line against the programmed value.
    always_comb match = (cur_line == cmp_line);

    // Remember the previous match level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match;
    end

    // Raise a hit only on the rising edge of the match.
    always_comb hit = match && !match_q;
endmodule

// File: rtl/disp_irq_status.sv
// Module: bank of sticky status bits, one per source. An event sets a bit
// and a clear resets it; a simultaneous event beats the clear.
module disp_irq_status
    import disp_irq_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt,
    input  logic [N_SRC-1:0] clr,
    output logic [N_SRC-1:0] stat_q
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        // One sticky bit: set on event, else cleared on request, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)      stat_q[i] <= 1'b0;
            else if (evt[i]) stat_q[i] <= 1'b1;
            else if (clr[i]) stat_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/disp_irq_ctrl.sv
// Module: top of the display interrupt controller. It packs status,
// enable, clear and line-number fields into one 32-bit word and ORs the
// enabled status bits onto irq. Assumes event inputs are one-cycle pulses.
module disp_irq_ctrl
    import disp_irq_pkg::*;
#(
    parameter int LW = LINE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [31:0]   wr_data,
    output logic [31:0]   rd_data,
    input  logic          evt_hold,
    input  logic          evt_frame,
    input  logic          evt_bus_err,
    input  logic [LW-1:0] cur_line,
    output logic          irq
);
    localparam int N = NUM_SRC;
    localparam int PAD_W = WORD_W - (LINE_LSB + LW);

    logic [N-1:0]  en_q;
    logic [N-1:0]  stat_q;
    logic [N-1:0]  evt;
    logic [N-1:0]  clr;
    logic [LW-1:0] line_q;
    logic          line_hit;

    disp_irq_cfg #(.N_SRC(N), .LW(LW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_en_bits (wr_data[EN_LSB +: N]),
        .wr_line    (wr_data[LINE_LSB +: LW]),
        .en_q       (en_q),
        .line_q     (line_q)
    );

    disp_line_det #(.LW(LW)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_line (cur_line),
        .cmp_line (line_q),
        .hit      (line_hit)
    );

    // Gather the event pulses into source order.
    always_comb begin
        evt = '0;
        evt[SRC_HOLD]   = evt_hold;
        evt[SRC_FRAME]  = evt_frame;
        evt[SRC_LINE]   = line_hit;
        evt[SRC_BUSERR] = evt_bus_err;
    end

    // Clear requests are valid only on a write cycle.
    always_comb clr = wr_en ? wr_data[CLR_LSB +: N] : '0;

    disp_irq_status #(.N_SRC(N)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .clr    (clr),
        .stat_q (stat_q)
    );

    // Assemble the read word; clear field and top bits read as zero.
    always_comb rd_data = {{PAD_W{1'b0}}, line_q, {N{1'b0}}, en_q, stat_q};

    // Interrupt when any enabled source has pending status.
    always_comb irq = |(stat_q & en_q);
endmodule

// File: rtl/disp_irq_ctrl_chk.sv
// Module: property checker for disp_irq_ctrl, attached through bind.
// Observes ports only.
module disp_irq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        evt_hold,
    input logic        evt_frame,
    input logic        evt_bus_err,
    input logic [12:0] cur_line,
    input logic        irq
);
    logic       was_rst_q;
    logic [3:0] keep;

    // Note that the previous edge was a reset edge.
    always_ff @(posedge clk) was_rst_q <= !rst_n;

    // Status bits that must survive this edge (no clear requested).
    always_comb keep = rd_data[3:0] & ~(wr_en ? wr_data[11:8] : 4'b0);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst_q |-> (rd_data == 32'h0) && !irq); // R1
    AST_HOLD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_hold |=> rd_data[0]); // R2
    AST_FRAME_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_frame |=> rd_data[1]); // R2
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rd_data[3:0] & $past(keep)) == $past(keep))); // R4
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[8] && !evt_hold) |=> !rd_data[0]); // R4
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[11] && evt_bus_err) |=> rd_data[3]); // R5
    AST_LINE_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[2]) |-> ($past(cur_line) == $past(rd_data[24:12]))); // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(rd_data[3:0] & rd_data[7:4])); // R9
endmodule

bind disp_irq_ctrl disp_irq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .evt_hold    (evt_hold),
    .evt_frame   (evt_frame),
    .evt_bus_err (evt_bus_err),
    .cur_line    (cur_line),
    .irq         (irq)
);

// File: tb/tb_disp_irq_ctrl.sv
// Directed bench for disp_irq_ctrl. Inputs change on falling edges and
// outputs are sampled on falling edges.
module tb_disp_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        evt_hold = 1'b0;
    logic        evt_frame = 1'b0;
    logic        evt_bus_err = 1'b0;
    logic [12:0] cur_line = 13'd5;
    logic        irq;

    int n_checks = 0;
    int n_errs   = 0;
    logic [31:0] cfg = '0;   // enable + line fields last written

    always #2 clk = ~clk;

    disp_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .evt_hold(evt_hold), .evt_frame(evt_frame),
        .evt_bus_err(evt_bus_err), .cur_line(cur_line), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic clear(logic [3:0] m);
        wr(cfg | {20'h0, m, 8'h0});
    endtask

    task automatic pulse(int src);
        if (src == 0) evt_hold = 1'b1;
        if (src == 1) evt_frame = 1'b1;
        if (src == 3) evt_bus_err = 1'b1;
        @(negedge clk);
        evt_hold = 1'b0; evt_frame = 1'b0; evt_bus_err = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 word", rd_data, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_events();
        pulse(0);
        check("R2 hold", {28'h0, rd_data[3:0]}, 32'h1);
        check("R9 disabled irq", {31'h0, irq}, 32'h0);
        pulse(3);
        check("R2 bus", {28'h0, rd_data[3:0]}, 32'h9);
        repeat (3) @(negedge clk);
        check("R2 sticky", {28'h0, rd_data[3:0]}, 32'h9);
        pulse(1);
        check("R2 frame", {28'h0, rd_data[3:0]}, 32'hB);
        clear(4'hF);
        check("R4 clear all", {28'h0, rd_data[3:0]}, 32'h0);
        check("R6 clear reads zero", {28'h0, rd_data[11:8]}, 32'h0);
    endtask

    task automatic t_enable_irq();
        cfg = 32'h0000_00A0;
        wr(cfg);
        check("R3 enables", {24'h0, rd_data[7:0]}, 32'hA0);
        pulse(0);
        check("R9 hold disabled", {31'h0, irq}, 32'h0);
        pulse(1);
        check("R9 frame enabled", {31'h0, irq}, 32'h1);
        clear(4'h2);
        check("R4 selective", {28'h0, rd_data[3:0]}, 32'h1);
        check("R9 irq dropped", {31'h0, irq}, 32'h0);
        clear(4'hF);
    endtask

    task automatic t_clear_vs_event();
        pulse(3);
        evt_bus_err = 1'b1;
        wr_en = 1'b1; wr_data = cfg | 32'h0000_0800;
        @(negedge clk);
        evt_bus_err = 1'b0; wr_en = 1'b0; wr_data = '0;
        check("R5 event wins", {31'h0, rd_data[3]}, 32'h1);
        check("R9 bus irq", {31'h0, irq}, 32'h1);
        clear(4'h8);
        check("R4 bus cleared", {28'h0, rd_data[3:0]}, 32'h0);
    endtask

    task automatic t_line();
        cfg = {7'h0, 13'd300, 12'h040};
        wr(cfg);
        check("R7 line readback", {19'h0, rd_data[24:12]}, 32'd300);
        check("R8 no early flag", {31'h0, rd_data[2]}, 32'h0);
        cur_line = 13'd300;
        @(negedge clk);
        check("R8 flag on match", {31'h0, rd_data[2]}, 32'h1);
        check("R9 line irq", {31'h0, irq}, 32'h1);
        clear(4'h4);
        @(negedge clk);
        check("R8 no refire while equal", {31'h0, rd_data[2]}, 32'h0);
        cur_line = 13'd301;
        @(negedge clk);
        cur_line = 13'd300;
        @(negedge clk);
        check("R8 refire after change", {31'h0, rd_data[2]}, 32'h1);
        cur_line = 13'd5;
        cfg = 32'h01FF_F000;
        wr(32'hFFFF_F000);
        clear(4'h4);
        check("R7 max line, top zero", rd_data, 32'h01FF_F000);
        cur_line = 13'd8191;
        @(negedge clk);
        check("R8 flag at 8191", {31'h0, rd_data[2]}, 32'h1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_events();
        t_enable_irq();
        t_clear_vs_event();
        t_line();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule